// File: doc/BRIEF.md
# Character Attribute and Brightness Renderer

This block decides, every clock, how each of the character cells of a small dot-matrix display is shown. It reads the stored character code of each cell, that cell's highlight flag and the global control fields (brightness level, highlight enable and highlight style, whole-display flash and lamp test). For each cell it produces a cell kind (dark, normal glyph, or every dot lit as a cursor), a lit strobe that applies brightness duty cycling, and the glyph index to pass on to a character generator.

Two free-running timebases live inside the block. The first is a duty counter that advances one step per clock and gates the LEDs for brightness and for the half-brightness cursor. The second is a blink timebase that flips between a visible and a hidden phase every `BLINK_HALF` clocks. A synchronous restart input returns the blink timebase to the start of its visible phase, so that several units sharing a clock and this restart blink in phase. The modes resolve in a fixed priority: zero brightness, then lamp test, then the hidden phase of the whole-display flash, then the per-cell highlight, then the plain glyph.

Top module: `glyph_render`

## Requirements
- R1: With `level_i` = 0 every cell kind is dark (kind code 0), every `lit_o` bit is 0 and every glyph index is 0, whatever the other inputs are.
- R2: The duty counter is 0 in the first clock after reset and advances by one each clock, and its step s is its value modulo 4. A cell of kind glyph (code 1) has its `lit_o` bit high at step 0 only when `level_i` = 1, at steps 0 and 1 when `level_i` = 2, and on every clock when `level_i` = 3.
- R3: A cell of kind cursor (code 2) is lit only when the glyph rule of R2 holds and the duty counter modulo 8 is below 4, so it gets half the glyph's on-time.
- R4: With `level_i` nonzero and `lamp_test_i` = 1, every cell is of kind cursor, regardless of flags, flash, highlight and codes.
- R5: With `level_i` nonzero, no lamp test, `flash_all_i` = 1 and the blink timebase in its hidden phase, every cell is dark; in the visible phase the flash has no effect.
- R6: A cell whose flag bit in `hilite_i` is 0, or any cell while `cue_en_i` = 0, is shown as glyph when no higher-priority mode applies.
- R7: Highlight style 0 (`cue_mode_i` = 0) shows a flagged cell as cursor in both blink phases.
- R8: Highlight style 1 shows a flagged cell as glyph in the visible phase and dark in the hidden phase.
- R9: Highlight style 2 shows a flagged cell as cursor in the visible phase and dark in the hidden phase.
- R10: Highlight style 3 shows a flagged cell as glyph in the visible phase and as cursor in the hidden phase.
- R11: The blink timebase is visible for the first `BLINK_HALF` clocks after reset or after a clock edge that sees `blink_sync_i` high, then hidden for `BLINK_HALF` clocks, alternating from there.
- R12: Highlighting holds no state of its own: a flagged cell shown as cursor returns to its stored glyph on the first clock in which `cue_en_i` is 0.
- R13: The glyph index of a cell (`glyph_o`, 7 bits per cell, cell i at bits 7i+6..7i) equals its stored code while the cell kind is glyph, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blink_sync_i | input | 1 | Restarts the blink timebase at its visible phase |
| char_code_i | input | NUM_CELLS*7 | Stored character codes, cell i at bits 7i+6..7i |
| hilite_i | input | NUM_CELLS | Per-cell highlight flag |
| level_i | input | 2 | Brightness: 0 dark, 1 quarter, 2 half, 3 full |
| cue_en_i | input | 1 | Enables highlighting of flagged cells |
| cue_mode_i | input | 2 | Highlight style, 0 to 3 |
| flash_all_i | input | 1 | Blinks the whole display |
| lamp_test_i | input | 1 | Lights every dot of every cell at half brightness |
| cell_kind_o | output | NUM_CELLS*2 | Cell kind, cell i at bits 2i+1..2i: 0 dark, 1 glyph, 2 cursor |
| lit_o | output | NUM_CELLS | Per-cell LED on strobe after duty cycling |
| glyph_o | output | NUM_CELLS*7 | Glyph index per cell for the character generator |

## Verification
The hardest situations to reach are those where a highlight style meets a particular blink phase and a particular duty step at once, since the phase only moves every `BLINK_HALF` clocks and the duty steps interleave with it. The bench shortens the blink half-period and keeps a cycle-accurate model of both timebases, so every random mix of styles, flags, flash, lamp test and brightness is checked on every clock across many phase flips. Occasional random restart pulses land the restart at arbitrary points of the phase, and directed runs step through one full blink period after a restart and through the release of a cursor back to its glyph.

// File: rtl/glyph_render_pkg.sv
package glyph_render_pkg;
  typedef enum logic [1:0] {
    CELL_DARK  = 2'b00,
    CELL_GLYPH = 2'b01,
    CELL_FULL  = 2'b10
  } cell_kind_e;

  typedef enum logic [1:0] {
    CUE_SOLID      = 2'd0,
    CUE_BLINK_CHAR = 2'd1,
    CUE_BLINK_FULL = 2'd2,
    CUE_ALTERNATE  = 2'd3
  } cue_mode_e;
endpackage

// File: rtl/glyph_duty_gen.sv
module glyph_duty_gen #(
  parameter int STEP_W = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] level_i,
  output logic       duty_on_o,
  output logic       half_on_o
);
  localparam int CNT_W = STEP_W + 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [STEP_W-1:0] step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign step = cnt_q[STEP_W-1:0];

  always_comb begin
    unique case (level_i)
      2'd0:    duty_on_o = 1'b0;
      2'd1:    duty_on_o = (step == '0);
      2'd2:    duty_on_o = ~step[STEP_W-1];
      default: duty_on_o = 1'b1;
    endcase
  end

  // cursor gets only the first half of each frame
  assign half_on_o = duty_on_o & ~cnt_q[CNT_W-1];

  assert_full_always_on_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == 2'd3) |-> duty_on_o);
  assert_half_within_duty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_on_o |-> duty_on_o);
  assert_half_alternates_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == 2'd3 && $past(level_i) == 2'd3 && $past(half_on_o) && !half_on_o)
      |-> $past(cnt_q) == {1'b0, {STEP_W{1'b1}}});
endmodule

// File: rtl/glyph_blink_timer.sv
module glyph_blink_timer #(
  parameter int BLINK_HALF = 12_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic visible_o
);
  localparam int CNT_W = $clog2(BLINK_HALF + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             vis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      vis_q <= 1'b1;
    end else if (sync_i) begin
      cnt_q <= '0;
      vis_q <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      vis_q <= ~vis_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign visible_o = vis_q;

  assert_sync_restarts_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (vis_q && cnt_q == '0));
  assert_phase_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && cnt_q != LAST) |=> $stable(vis_q));
  assert_count_bounded_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/glyph_cell_resolver.sv
module glyph_cell_resolver
  import glyph_render_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        level_i,
  input  logic              lamp_test_i,
  input  logic              flash_all_i,
  input  logic              visible_i,
  input  logic              cue_en_i,
  input  logic [1:0]        cue_mode_i,
  input  logic              flag_i,
  input  logic              duty_on_i,
  input  logic              half_on_i,
  input  logic [CODE_W-1:0] code_i,
  output cell_kind_e        kind_o,
  output logic              lit_o,
  output logic [CODE_W-1:0] glyph_o
);
  cell_kind_e cue_kind;

  always_comb begin
    unique case (cue_mode_e'(cue_mode_i))
      CUE_SOLID:      cue_kind = CELL_FULL;
      CUE_BLINK_CHAR: cue_kind = visible_i ? CELL_GLYPH : CELL_DARK;
      CUE_BLINK_FULL: cue_kind = visible_i ? CELL_FULL  : CELL_DARK;
      default:        cue_kind = visible_i ? CELL_GLYPH : CELL_FULL;
    endcase
  end

  always_comb begin
    if (level_i == 2'd0)               kind_o = CELL_DARK;
    else if (lamp_test_i)              kind_o = CELL_FULL;
    else if (flash_all_i && !visible_i) kind_o = CELL_DARK;
    else if (cue_en_i && flag_i)       kind_o = cue_kind;
    else                               kind_o = CELL_GLYPH;
  end

  assign lit_o   = ((kind_o == CELL_GLYPH) && duty_on_i) || ((kind_o == CELL_FULL) && half_on_i);
  assign glyph_o = (kind_o == CELL_GLYPH) ? code_i : '0;

  assert_lamp_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != 2'd0 && lamp_test_i) |-> kind_o == CELL_FULL);
  assert_plain_glyph_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != 2'd0 && !lamp_test_i && !(flash_all_i && !visible_i) && !(cue_en_i && flag_i))
      |-> kind_o == CELL_GLYPH);
  assert_solid_cursor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != 2'd0 && !lamp_test_i && !flash_all_i && cue_en_i && flag_i && cue_mode_i == 2'd0)
      |-> kind_o == CELL_FULL);
  assert_alternate_never_dark_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != 2'd0 && !flash_all_i && cue_en_i && flag_i && cue_mode_i == 2'd3)
      |-> kind_o != CELL_DARK);
  assert_index_masked_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o != CELL_GLYPH) |-> glyph_o == '0);
endmodule

// File: rtl/glyph_render.sv
module glyph_render
  import glyph_render_pkg::*;
#(
  parameter int NUM_CELLS  = 4,
  parameter int CODE_W     = 7,
  parameter int BLINK_HALF = 12_500_000
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        blink_sync_i,
  input  logic [NUM_CELLS*CODE_W-1:0] char_code_i,
  input  logic [NUM_CELLS-1:0]        hilite_i,
  input  logic [1:0]                  level_i,
  input  logic                        cue_en_i,
  input  logic [1:0]                  cue_mode_i,
  input  logic                        flash_all_i,
  input  logic                        lamp_test_i,
  output logic [NUM_CELLS*2-1:0]      cell_kind_o,
  output logic [NUM_CELLS-1:0]        lit_o,
  output logic [NUM_CELLS*CODE_W-1:0] glyph_o
);
  logic duty_on, half_on, visible;

  glyph_duty_gen #(.STEP_W(2)) u_duty (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level_i),
    .duty_on_o (duty_on),
    .half_on_o (half_on)
  );

  glyph_blink_timer #(.BLINK_HALF(BLINK_HALF)) u_blink (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (blink_sync_i),
    .visible_o (visible)
  );

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    cell_kind_e kind;

    glyph_cell_resolver #(.CODE_W(CODE_W)) u_res (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .level_i     (level_i),
      .lamp_test_i (lamp_test_i),
      .flash_all_i (flash_all_i),
      .visible_i   (visible),
      .cue_en_i    (cue_en_i),
      .cue_mode_i  (cue_mode_i),
      .flag_i      (hilite_i[c]),
      .duty_on_i   (duty_on),
      .half_on_i   (half_on),
      .code_i      (char_code_i[c*CODE_W +: CODE_W]),
      .kind_o      (kind),
      .lit_o       (lit_o[c]),
      .glyph_o     (glyph_o[c*CODE_W +: CODE_W])
    );

    assign cell_kind_o[c*2 +: 2] = kind;
  end

  assert_blank_all_dark_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == 2'd0) |-> (lit_o == '0 && cell_kind_o == '0));
  assert_flash_hides_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != 2'd0 && !lamp_test_i && flash_all_i && !visible) |-> cell_kind_o == '0);
  assert_one_kind_per_cell_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lamp_test_i && level_i != 2'd0) |-> $countones(lit_o) == 0 || lit_o == '1);
endmodule

// File: tb/glyph_render_tb_top.sv
module glyph_render_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int CW         = 7;
  localparam int HALF       = 6;
  localparam int WATCHDOG   = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync = 1'b0;
  logic [N*CW-1:0] codes = '0;
  logic [N-1:0]  flags = '0;
  logic [1:0]    level = 2'd3;
  logic          cue_en = 1'b0;
  logic [1:0]    cue_mode = 2'd0;
  logic          flash = 1'b0;
  logic          lamp = 1'b0;
  logic [N*2-1:0]  kind_w;
  logic [N-1:0]    lit_w;
  logic [N*CW-1:0] glyph_w;

  int checks = 0;
  int fails  = 0;
  int dcnt   = 0;
  int bcnt   = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  glyph_render #(.NUM_CELLS(N), .CODE_W(CW), .BLINK_HALF(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .blink_sync_i(sync), .char_code_i(codes),
    .hilite_i(flags), .level_i(level), .cue_en_i(cue_en), .cue_mode_i(cue_mode),
    .flash_all_i(flash), .lamp_test_i(lamp),
    .cell_kind_o(kind_w), .lit_o(lit_w), .glyph_o(glyph_w)
  );

  // reference timebases from R2 and R11
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin dcnt <= 0; bcnt <= 0; end
    else begin dcnt <= dcnt + 1; bcnt <= sync ? 0 : bcnt + 1; end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic bit ref_vis();
    return ((bcnt / HALF) % 2) == 0;
  endfunction

  function automatic int ref_kind(input int c, output string tag);
    bit vis = ref_vis();
    if (level == 0) begin tag = "R1"; return 0; end
    if (lamp) begin tag = "R4"; return 2; end
    if (flash && !vis) begin tag = "R5"; return 0; end
    if (cue_en && flags[c]) begin
      case (cue_mode)
        2'd0: begin tag = "R7";  return 2; end
        2'd1: begin tag = "R8";  return vis ? 1 : 0; end
        2'd2: begin tag = "R9";  return vis ? 2 : 0; end
        default: begin tag = "R10"; return vis ? 1 : 2; end
      endcase
    end
    tag = "R6";
    return 1;
  endfunction

  function automatic bit ref_lit(input int k);
    int  s = dcnt % 4;
    bit  on = (level == 3) || (level == 2 && s < 2) || (level == 1 && s == 0);
    if (k == 1) return on;
    if (k == 2) return on && ((dcnt % 8) < 4);
    return 1'b0;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, got, exp);
    end
  endtask

  task automatic check_all();
    for (int c = 0; c < N; c++) begin
      string tag;
      int k = ref_kind(c, tag);
      check(tag, int'(kind_w[c*2 +: 2]), k);
      check(k == 2 ? "R3" : (k == 1 ? "R2" : "R1"), int'(lit_w[c]), int'(ref_lit(k)));
      check("R13", int'(glyph_w[c*CW +: CW]), k == 1 ? int'(codes[c*CW +: CW]) : 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    codes = {7'h53, 7'h54, 7'h4f, 7'h50};
    #(CLK_PERIOD * 3);
    // reset state: timebase visible, duty step 0
    #1;
    check("R11", int'(kind_w[1:0]), 1);
    check("R2", int'(lit_w[0]), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 / R3: sweep brightness over two frames each, glyph then lamp test cursor
    for (int lv = 0; lv < 4; lv++) begin
      for (int lt = 0; lt < 2; lt++) begin
        level = 2'(lv); lamp = lt[0];
        for (int i = 0; i < 16; i++) begin
          @(negedge clk); #1; check_all();
        end
      end
    end
    lamp = 1'b0;

    // R11: restart, then one full blink period with whole-display flash
    level = 2'd3; flash = 1'b1; sync = 1'b1;
    @(negedge clk); sync = 1'b0;
    for (int k = 0; k < 2 * HALF + 2; k++) begin
      #1;
      check("R11", int'(kind_w[3:2]), ((k / HALF) % 2 == 0) ? 1 : 0);
      @(negedge clk);
    end
    flash = 1'b0;

    // R12: cursor releases back to the stored glyph
    flags = 4'b0110; cue_en = 1'b1; cue_mode = 2'd0;
    @(negedge clk); #1;
    check("R12", int'(kind_w[3:2]), 2);
    check("R12", int'(glyph_w[CW +: CW]), 0);
    cue_en = 1'b0;
    @(negedge clk); #1;
    check("R12", int'(kind_w[3:2]), 1);
    check("R12", int'(glyph_w[CW +: CW]), int'(codes[CW +: CW]));

    // each style over a full blink period, all cells flagged
    cue_en = 1'b1; flags = '1;
    for (int m = 0; m < 4; m++) begin
      cue_mode = 2'(m);
      for (int i = 0; i < 2 * HALF; i++) begin
        @(negedge clk); #1; check_all();
      end
    end

    // constrained random mix
    for (int it = 0; it < 4000; it++) begin
      @(negedge clk);
      sync     = ($urandom % 64) == 0;
      level    = ($urandom % 8 == 0) ? 2'd0 : 2'(1 + $urandom % 3);
      lamp     = ($urandom % 8) == 0;
      flash    = ($urandom % 4) == 0;
      cue_en   = ($urandom % 2) == 0;
      cue_mode = 2'($urandom % 4);
      flags    = N'($urandom);
      codes    = (N*CW)'({$urandom, $urandom});
      #1;
      check_all();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule